// File: doc/BRIEF.md
# Index-Reset Position Counter with Latch

This block counts edges on an external count input with a 32-bit position counter. An index input, typically a once-per-second reference pulse, reloads the counter from a programmable start value. Just before each reload, the running count is captured into an index-latch register. With a precise reference on the index input, that captured value is the number of count-input edges per reference period, so the block works as a frequency meter. Each index event also sets a flag that can raise an interrupt line.

Both external inputs are asynchronous. Each passes through a two-flop synchronizer, and edges are detected on the synchronized level. Software reaches the block through a small register port. A write takes effect at the clock edge where `bus_wr` is high. A read issued with `bus_rd` returns its data one cycle later, with `rd_valid` high for exactly one cycle. The read side offers no back-pressure: the requester must take every `rd_valid` beat in the cycle it appears.

Register addresses:
- 0: control
- 1: position counter (read/write)
- 2: start value
- 3: ceiling
- 4: index latch (read only)
- 5: interrupt enable, bit 0
- 6: index flag, bit 0
- 7: status, bit 0
- 8: flag clear (write only, reads 0)

Control register fields:
- bit 0: count enable
- bits [2:1]: source select
- bit 3: rising-only
- bits [5:4]: index edge
- bits [7:6]: reset mode

Top module: `idx_pos_counter`

## Requirements
- R1: After reset, the registers read as follows: control 0, position 0, start value 0, ceiling all ones, index latch 0, interrupt enable 0, flag 0, status 0. `irq` is low.
- R2: The counter increments by one on a counted edge only when control bit 0 is 1 and control bits [2:1] equal 2. Any other source-select value leaves the counter unchanged.
- R3: When control bit 3 is 1, only rising edges of `cnt_in` are counted. When bit 3 is 0, rising and falling edges are both counted.
- R4: While control bit 0 is 0, the counter holds its value and is not reloaded by an index event. The index latch and the flag still update on index events.
- R5: Control bits [5:4] select the index event: 0 none, 1 rising edge of `idx_in`, 2 falling edge, 3 both edges.
- R6: On every index event, the index latch (address 4) captures the count. If control bits [7:6] are 0, the counter is then loaded from the start value (address 2). Any other reset-mode value leaves the counter running.
- R7: Every index event sets the flag (address 6, bit 0). `irq` equals the flag ANDed with the enable (address 5, bit 0). Writing 1 to bit 0 of address 8 clears the flag. If an index event and a clear fall in the same cycle, the index event wins.
- R8: An increment from a value at or above the ceiling (address 3) gives 0. With the ceiling at all ones, the counter wraps from 0xFFFFFFFF to 0.
- R9: When a counted edge and an index event fall in the same cycle, the reload wins. The latch receives the count including that coincident edge.
- R10: Status bit 0 (address 7) goes to 1 at the first index event and stays 1 until block reset. Flag clears do not affect it.
- R11: A level change on `cnt_in` is counted exactly once. It shows in the counter at the third rising clock edge after the change.
- R12: A write to address 1 loads the counter. The write takes priority over counting and index reload in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_in | input | 1 | Asynchronous count input |
| idx_in | input | 1 | Asynchronous index input |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read request |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Register write data |
| rd_valid | output | 1 | Read data valid, one cycle after `bus_rd` |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Index interrupt, flag AND enable |

## Verification
A wrong count or latch state shows up at the next read of address 1 or 4, one cycle after the request. An error on the counting path also corrupts every later latch value, because each period's measurement starts from the reloaded value. Flag or enable faults appear on `irq` in the cycle after the index event reaches the core, about three clocks after the input edge. The bench reads back the counter and latch after every stimulus group. It probes the exact cycle in which a counted edge first becomes visible. It also drives the corner cases: coincident count and index edges, the ceiling wrap, and index handling while counting is disabled.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_CTRL = 4'd0;
  localparam logic [AW-1:0] A_POS  = 4'd1;
  localparam logic [AW-1:0] A_INIT = 4'd2;
  localparam logic [AW-1:0] A_MAX  = 4'd3;
  localparam logic [AW-1:0] A_ILAT = 4'd4;
  localparam logic [AW-1:0] A_IEN  = 4'd5;
  localparam logic [AW-1:0] A_FLAG = 4'd6;
  localparam logic [AW-1:0] A_STAT = 4'd7;
  localparam logic [AW-1:0] A_CLR  = 4'd8;

  localparam logic [1:0] SRC_UPCOUNT = 2'd2;
  localparam logic [1:0] IDX_NONE    = 2'd0;
  localparam logic [1:0] IDX_RISE    = 2'd1;
  localparam logic [1:0] IDX_FALL    = 2'd2;
  localparam logic [1:0] IDX_BOTH    = 2'd3;
  localparam logic [1:0] RM_ON_INDEX = 2'd0;

  // packed MSB first: rst_mode [7:6], idx_edge [5:4], rise_only [3],
  // src_sel [2:1], cnt_en [0]
  typedef struct packed {
    logic [1:0] rst_mode;
    logic [1:0] idx_edge;
    logic       rise_only;
    logic [1:0] src_sel;
    logic       cnt_en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ipc_edge_sync.sv
module ipc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-1:0], din};
  end

  assign rise =  chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/ipc_pos_core.sv
module ipc_pos_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_fire,
  input  logic         idx_fire,
  input  logic         reload_en,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] max_val,
  input  logic         pos_wr,
  input  logic [W-1:0] pos_wdata,
  output logic [W-1:0] pos,
  output logic [W-1:0] ilatch
);
  logic [W-1:0] pos_inc;
  logic [W-1:0] pos_seen;

  assign pos_inc  = (pos >= max_val) ? '0 : pos + 1'b1;
  assign pos_seen = cnt_fire ? pos_inc : pos;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (pos_wr) begin
      pos <= pos_wdata;
    end else if (cnt_en) begin
      if (idx_fire && reload_en) pos <= init_val;
      else if (cnt_fire)         pos <= pos_inc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        ilatch <= '0;
    else if (idx_fire) ilatch <= pos_seen;
  end
endmodule

// File: rtl/ipc_regs.sv
module ipc_regs import ipc_pkg::*; #(
  parameter int W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic          idx_fire,
  input  logic [W-1:0]  pos,
  input  logic [W-1:0]  ilatch,
  output ctrl_t         ctrl,
  output logic [W-1:0]  init_val,
  output logic [W-1:0]  max_val,
  output logic          pos_wr,
  output logic          index_flag,
  output logic          seen,
  output logic          irq,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data
);
  localparam int PAD = W - CTRL_W;

  logic         ien;
  logic         clr_hit;
  logic [W-1:0] rd_mux;

  assign pos_wr  = bus_wr && (bus_addr == A_POS);
  assign clr_hit = bus_wr && (bus_addr == A_CLR) && bus_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      init_val <= '0;
      max_val  <= '1;
      ien      <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_CTRL:  ctrl     <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        A_INIT:  init_val <= bus_wdata;
        A_MAX:   max_val  <= bus_wdata;
        A_IEN:   ien      <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_flag <= 1'b0;
      seen       <= 1'b0;
    end else begin
      if (idx_fire)     index_flag <= 1'b1;
      else if (clr_hit) index_flag <= 1'b0;
      if (idx_fire)     seen       <= 1'b1;
    end
  end

  assign irq = index_flag & ien;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL: rd_mux = {{PAD{1'b0}}, ctrl};
      A_POS:  rd_mux = pos;
      A_INIT: rd_mux = init_val;
      A_MAX:  rd_mux = max_val;
      A_ILAT: rd_mux = ilatch;
      A_IEN:  rd_mux = {{(W-1){1'b0}}, ien};
      A_FLAG: rd_mux = {{(W-1){1'b0}}, index_flag};
      A_STAT: rd_mux = {{(W-1){1'b0}}, seen};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/idx_pos_counter.sv
module idx_pos_counter import ipc_pkg::*; #(
  parameter int W          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_in,
  input  logic          idx_in,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic          irq
);
  logic         c_rise, c_fall, i_rise, i_fall;
  logic         cnt_fire, idx_fire, reload_en;
  logic         pos_wr, index_flag, seen;
  ctrl_t        ctrl;
  logic [W-1:0] init_val, max_val, pos, ilatch;

  ipc_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .rise(c_rise), .fall(c_fall));

  ipc_edge_sync #(.STAGES(SYNC_STAGES)) u_idx_sync (
    .clk(clk), .rst_n(rst_n), .din(idx_in), .rise(i_rise), .fall(i_fall));

  assign cnt_fire = ctrl.cnt_en && (ctrl.src_sel == SRC_UPCOUNT) &&
                    (ctrl.rise_only ? c_rise : (c_rise | c_fall));

  always_comb begin
    case (ctrl.idx_edge)
      IDX_RISE: idx_fire = i_rise;
      IDX_FALL: idx_fire = i_fall;
      IDX_BOTH: idx_fire = i_rise | i_fall;
      default:  idx_fire = 1'b0;
    endcase
  end

  assign reload_en = (ctrl.rst_mode == RM_ON_INDEX);

  ipc_pos_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(ctrl.cnt_en), .cnt_fire(cnt_fire),
    .idx_fire(idx_fire), .reload_en(reload_en), .init_val(init_val),
    .max_val(max_val), .pos_wr(pos_wr), .pos_wdata(bus_wdata),
    .pos(pos), .ilatch(ilatch));

  ipc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .idx_fire(idx_fire),
    .pos(pos), .ilatch(ilatch), .ctrl(ctrl), .init_val(init_val),
    .max_val(max_val), .pos_wr(pos_wr), .index_flag(index_flag),
    .seen(seen), .irq(irq), .rd_valid(rd_valid), .rd_data(rd_data));
endmodule

// File: rtl/idx_pos_counter_chk.sv
module idx_pos_counter_chk import ipc_pkg::*; #(
  parameter int W = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic          cnt_en,
  input logic          cnt_fire,
  input logic          idx_fire,
  input logic          reload_en,
  input logic          pos_wr,
  input logic [W-1:0]  pos,
  input logic [W-1:0]  ilatch,
  input logic [W-1:0]  init_val,
  input logic [W-1:0]  max_val,
  input logic          index_flag,
  input logic          seen
);
  // R6
  reload_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_fire && cnt_en && reload_en && !pos_wr |=> pos == $past(init_val));

  // R6
  latch_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_fire && !cnt_fire |=> ilatch == $past(pos));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en && !pos_wr |=> $stable(pos));

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_fire |=> index_flag);

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_CLR && bus_wdata[0] && !idx_fire |=> !index_flag);

  // R10
  seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(seen));

  // R8
  ceiling_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_fire && !idx_fire && !pos_wr && pos >= max_val |=> pos == '0);
endmodule

bind idx_pos_counter idx_pos_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt_en(ctrl.cnt_en), .cnt_fire(cnt_fire),
  .idx_fire(idx_fire), .reload_en(reload_en), .pos_wr(pos_wr), .pos(pos),
  .ilatch(ilatch), .init_val(init_val), .max_val(max_val),
  .index_flag(index_flag), .seen(seen));

// File: tb/idx_pos_counter_bench.sv
module idx_pos_counter_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_in = 1'b0, idx_in = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rd_valid, irq;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  idx_pos_counter u_idx_pos_counter (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .idx_in(idx_in),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq));

  // monitor: pops expected read data as rd_valid beats arrive
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read beat: actual %h expected none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cnt_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_in = 1'b1; settle(3);
      cnt_in = 1'b0; settle(3);
    end
    settle(2);
  endtask

  task automatic idx_pulse();
    idx_in = 1'b1; settle(4);
    idx_in = 1'b0; settle(4);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: actual irq %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    rd(4'd0, 32'h0, "R1 ctrl");
    rd(4'd1, 32'h0, "R1 pos");
    rd(4'd2, 32'h0, "R1 init");
    rd(4'd3, 32'hFFFF_FFFF, "R1 max");
    rd(4'd4, 32'h0, "R1 ilatch");
    rd(4'd6, 32'h0, "R1 flag");
    rd(4'd7, 32'h0, "R1 status");
    chk_irq(1'b0, "R1 irq");

    // R11 latency: visible at third edge after change
    wr(4'd0, 32'h1D);
    cnt_in = 1'b1;
    settle(2);
    rd(4'd1, 32'd0, "R11 before third edge");
    rd(4'd1, 32'd1, "R11 at third edge");
    cnt_in = 1'b0; settle(4);
    // R2 up-count rising only
    cnt_pulses(4);
    rd(4'd1, 32'd5, "R2 rising count");
    // R3 both edges
    wr(4'd0, 32'h15);
    cnt_pulses(3);
    rd(4'd1, 32'd11, "R3 both edges");
    // R4 disabled: no count, no reload, latch and flag still update
    wr(4'd0, 32'h1C);
    cnt_pulses(4);
    idx_pulse();
    rd(4'd1, 32'd11, "R4 held");
    rd(4'd4, 32'd11, "R4 latch while off");
    rd(4'd6, 32'd1, "R4 flag while off");
    wr(4'd8, 32'h1);

    // R6 R7 index reload, latch, irq
    wr(4'd0, 32'h1D);
    wr(4'd2, 32'd100);
    wr(4'd5, 32'h1);
    chk_irq(1'b0, "R7 irq before event");
    idx_pulse();
    rd(4'd4, 32'd11, "R6 latch");
    rd(4'd1, 32'd100, "R6 reload");
    chk_irq(1'b1, "R7 irq raised");
    rd(4'd7, 32'd1, "R10 status set");
    cnt_pulses(2);
    wr(4'd8, 32'h1);
    rd(4'd6, 32'd0, "R7 flag cleared");
    chk_irq(1'b0, "R7 irq cleared");
    wr(4'd5, 32'h0);
    idx_pulse();
    rd(4'd6, 32'd1, "R7 flag with irq masked");
    chk_irq(1'b0, "R7 irq masked");
    rd(4'd4, 32'd102, "R6 second latch");

    // R8 ceiling
    wr(4'd3, 32'd103);
    cnt_pulses(5);
    rd(4'd1, 32'd1, "R8 ceiling wrap");
    wr(4'd3, 32'hFFFF_FFFF);
    wr(4'd1, 32'hFFFF_FFFE);
    rd(4'd1, 32'hFFFF_FFFE, "R12 counter write");
    cnt_pulses(3);
    rd(4'd1, 32'd1, "R8 full span wrap");

    // R5 falling index edge
    wr(4'd0, 32'h2D);
    wr(4'd1, 32'd50);
    idx_in = 1'b1; settle(4);
    rd(4'd4, 32'd102, "R5 rising ignored");
    rd(4'd1, 32'd50, "R5 no reload on rise");
    idx_in = 1'b0; settle(4);
    rd(4'd4, 32'd50, "R5 falling latch");
    rd(4'd1, 32'd100, "R5 falling reload");

    // R6 reset mode nonzero: latch only
    wr(4'd0, 32'h5D);
    wr(4'd1, 32'd7);
    idx_pulse();
    rd(4'd4, 32'd7, "R6 mode1 latch");
    rd(4'd1, 32'd7, "R6 mode1 no reload");

    // R9 coincident count and index
    wr(4'd0, 32'h1D);
    wr(4'd1, 32'd20);
    cnt_in = 1'b1; idx_in = 1'b1;
    settle(4);
    rd(4'd4, 32'd21, "R9 latch includes count");
    rd(4'd1, 32'd100, "R9 reload wins");
    cnt_in = 1'b0; idx_in = 1'b0;
    settle(4);

    // R10 status survives clear
    wr(4'd8, 32'h1);
    rd(4'd6, 32'd0, "R10 flag cleared");
    rd(4'd7, 32'd1, "R10 status sticky");

    // R2 other source select does not count
    wr(4'd0, 32'h1B);
    cnt_pulses(3);
    rd(4'd1, 32'd100, "R2 source select not 2");

    settle(3);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule